// File: doc/BRIEF.md
# SD Data FIFO Byte Packer

This block is the data path of an SD host controller. Software sees a 32-bit data port backed by a 16-word FIFO. The card side is one byte wide, with a valid/ready handshake in each direction. On a read transfer, bytes from the card are packed into FIFO words, first byte lowest. On a write transfer, FIFO words are split into bytes for the card, least significant byte first.

A remaining-byte counter is loaded with block size times block count, and the transfer stops when it reaches zero. The block keeps sticky status flags for data movement, the data interrupt and the block interrupt. A debug word reports the FIFO fill level and a small transfer-state code.

Top module: `sdp_datapath`

## Requirements
- R1: The FIFO holds DEPTH (16) words of 32 bits. A push while it holds 16 words is dropped and the level stays 16. The level always appears on `dbg[8:4]`.
- R2: While the FIFO is empty, `dat_rd_data` is 0, and a pop leaves the level at 0.
- R3: A pulse on `count_load` sets the remaining count to `blk_size * blk_count` and discards any partly packed or unpacked word. Each card byte handshake lowers the count by one.
- R4: In read direction (`dir_write`=0), `card_rx_ready` is high only while the count is nonzero and the FIFO is not full. Accepted bytes fill a word at bits 7:0, then 15:8, 23:16 and 31:24, and the full word is pushed into the FIFO.
- R5: If the count reaches zero partway through a word on a read, that word is pushed with its unfilled upper bytes set to zero.
- R6: In write direction (`dir_write`=1), each word popped from the FIFO is offered on `card_tx_data` least significant byte first, four bytes per word. Bytes are offered only while the count is nonzero. `card_tx_valid` is never high in read direction.
- R7: Every word the card side moves through the FIFO sets `status[0]`. When `cfg_data_irq_en` is 1, it also sets `status[8]`.
- R8: In write direction, when a byte handshake leaves a remaining count that is a nonzero multiple of a nonzero block size, or that is zero, and `cfg_block_irq_en` is 1, `status[9]` is set. With the enable at 0, the bit is not set.
- R9: `dbg[3:0]` is 0 after reset and after a load with a nonzero product. It becomes 1 when the count reaches zero through a byte handshake, or after a load with a zero product.
- R10: A software push (`dat_wr_en`) is honoured only in write direction. A software pop (`dat_rd_en`) is honoured only in read direction. Otherwise the FIFO is unchanged.
- R11: Status bits are sticky and are cleared by writing 1s to `stat_clr`. A set in the same cycle wins over a clear. `irq` is `status[8] | status[9]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_write | input | 1 | 1 = write transfer (host to card), 0 = read |
| cfg_data_irq_en | input | 1 | Enable status[8] on word movement |
| cfg_block_irq_en | input | 1 | Enable status[9] at block boundaries |
| blk_size | input | SIZE_W | Block size in bytes |
| blk_count | input | COUNT_W | Number of blocks |
| count_load | input | 1 | Load remaining count with size times count |
| dat_wr_en | input | 1 | Software push strobe |
| dat_wr_data | input | WORD_W | Software push word |
| dat_rd_en | input | 1 | Software pop strobe |
| dat_rd_data | output | WORD_W | FIFO head word, 0 when empty |
| stat_clr | input | 10 | Write-1-to-clear mask for status |
| status | output | 10 | Bit 0 data flag, bit 8 data irq, bit 9 block irq |
| irq | output | 1 | Interrupt request |
| dbg | output | LW+4 | Fill level in [LW+3:4], state code in [3:0] |
| card_rx_valid | input | 1 | Card byte available |
| card_rx_data | input | 8 | Card byte |
| card_rx_ready | output | 1 | Block accepts card byte |
| card_tx_valid | output | 1 | Byte offered to card |
| card_tx_data | output | 8 | Byte to card |
| card_tx_ready | input | 1 | Card accepts byte |

## Verification
Each registered result appears one clock edge after its stimulus. The FIFO level, the status bits, the state code and the pushed word all follow the handshake or strobe edge that causes them, so the bench drives inputs and reads outputs only at falling edges. On a write transfer, a byte reaches `card_tx_data` one edge after the pop that fetches its word. The card tasks therefore wait at falling edges for valid or ready before sampling, and they check a result only once the producing rising edge has passed. The combinational head word is read on the falling edge before the pop strobe.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
   localparam int ST_W    = 10;
   localparam int ST_DATA = 0;
   localparam int ST_DIRQ = 8;
   localparam int ST_BIRQ = 9;

   typedef enum logic [3:0] {
      XS_RUN  = 4'h0,
      XS_DONE = 4'h1
   } xfer_state_e;
endpackage

// File: rtl/sdp_fifo.sv
module sdp_fifo #(
   parameter  int DEPTH = 16,
   parameter  int WIDTH = 32,
   localparam int LW    = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic [LW-1:0]    level,
   output logic             full,
   output logic             empty
);
   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("sdp_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wptr, rptr;
   logic             push_ok, pop_ok;

   assign full    = (level == LW'(DEPTH));
   assign empty   = (level == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign rdata   = empty ? '0 : mem[rptr];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         level <= '0;
      end else begin
         if (push_ok) wptr <= wptr + AW'(1);
         if (pop_ok)  rptr <= rptr + AW'(1);
         case ({push_ok, pop_ok})
            2'b10:   level <= level + LW'(1);
            2'b01:   level <= level - LW'(1);
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/sdp_pack.sv
module sdp_pack #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              take,
   input  logic [7:0]        byte_in,
   input  logic              last,
   output logic              push,
   output logic [WORD_W-1:0] word
);
   localparam int NB = WORD_W / 8;
   localparam int IW = $clog2(NB);

   logic [IW-1:0]     idx;
   logic [WORD_W-1:0] acc, merged;

   for (genvar g = 0; g < NB; g++) begin : g_lane
      assign merged[g*8 +: 8] = (take && idx == IW'(g)) ? byte_in : acc[g*8 +: 8];
   end

   assign push = take && (last || idx == IW'(NB - 1));
   assign word = merged;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         acc <= '0;
         idx <= '0;
      end else if (take) begin
         if (push) begin
            acc <= '0;
            idx <= '0;
         end else begin
            acc <= merged;
            idx <= idx + IW'(1);
         end
      end
   end
endmodule

// File: rtl/sdp_unpack.sv
module sdp_unpack #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              can_fetch,
   input  logic [WORD_W-1:0] word_in,
   input  logic              give,
   output logic              fetch,
   output logic              have,
   output logic [7:0]        byte_out
);
   localparam int NB = WORD_W / 8;
   localparam int CW = $clog2(NB + 1);

   logic [WORD_W-1:0] hold;
   logic [CW-1:0]     left;

   assign have     = (left != '0);
   assign fetch    = can_fetch && !have;
   assign byte_out = hold[7:0];

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         hold <= '0;
         left <= '0;
      end else if (fetch) begin
         hold <= word_in;
         left <= CW'(NB);
      end else if (give) begin
         hold <= hold >> 8;
         left <= left - CW'(1);
      end
   end
endmodule

// File: rtl/sdp_datapath.sv
module sdp_datapath #(
   parameter  int DEPTH   = 16,
   parameter  int WORD_W  = 32,
   parameter  int SIZE_W  = 12,
   parameter  int COUNT_W = 9,
   localparam int LW      = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               dir_write,
   input  logic               cfg_data_irq_en,
   input  logic               cfg_block_irq_en,
   input  logic [SIZE_W-1:0]  blk_size,
   input  logic [COUNT_W-1:0] blk_count,
   input  logic               count_load,
   input  logic               dat_wr_en,
   input  logic [WORD_W-1:0]  dat_wr_data,
   input  logic               dat_rd_en,
   output logic [WORD_W-1:0]  dat_rd_data,
   input  logic [9:0]         stat_clr,
   output logic [9:0]         status,
   output logic               irq,
   output logic [LW+3:0]      dbg,
   input  logic               card_rx_valid,
   input  logic [7:0]         card_rx_data,
   output logic               card_rx_ready,
   output logic               card_tx_valid,
   output logic [7:0]         card_tx_data,
   input  logic               card_tx_ready
);
   import sdp_pkg::*;

   localparam int REM_W = SIZE_W + COUNT_W;

   if (WORD_W < 16 || (WORD_W % 8) != 0) begin : g_bad_word
      $error("sdp_datapath: WORD_W must be a multiple of 8, at least 16");
   end
   if (SIZE_W < 1 || COUNT_W < 1) begin : g_bad_count
      $error("sdp_datapath: SIZE_W and COUNT_W must be positive");
   end

   logic [REM_W-1:0]  rem_q, load_val;
   logic [SIZE_W-1:0] blk_left;
   xfer_state_e       xs_q;
   logic [ST_W-1:0]   stat_q, stat_set;
   logic              active, rx_fire, tx_fire, last_byte, blk_hit, word_moved;

   logic              fifo_push, fifo_pop, fifo_full, fifo_empty;
   logic [WORD_W-1:0] fifo_wdata, fifo_rdata;
   logic [LW-1:0]     fifo_level;

   logic              pk_push;
   logic [WORD_W-1:0] pk_word;
   logic              up_fetch, up_have;
   logic [7:0]        up_byte;

   assign load_val  = REM_W'(blk_size) * REM_W'(blk_count);
   assign active    = (rem_q != '0);
   assign last_byte = (rem_q == REM_W'(1));

   assign card_rx_ready = !dir_write && active && !fifo_full;
   assign card_tx_valid = dir_write && active && up_have;
   assign card_tx_data  = up_byte;
   assign rx_fire       = card_rx_valid && card_rx_ready;
   assign tx_fire       = card_tx_valid && card_tx_ready;

   // software side is steered by direction; card side owns the other port
   assign fifo_push  = dir_write ? dat_wr_en   : pk_push;
   assign fifo_wdata = dir_write ? dat_wr_data : pk_word;
   assign fifo_pop   = dir_write ? up_fetch    : dat_rd_en;
   assign dat_rd_data = fifo_rdata;

   sdp_fifo #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(fifo_push), .wdata(fifo_wdata),
      .pop(fifo_pop), .rdata(fifo_rdata),
      .level(fifo_level), .full(fifo_full), .empty(fifo_empty)
   );

   sdp_pack #(.WORD_W(WORD_W)) u_pack (
      .clk(clk), .rst_n(rst_n), .clear(count_load),
      .take(rx_fire), .byte_in(card_rx_data), .last(last_byte),
      .push(pk_push), .word(pk_word)
   );

   sdp_unpack #(.WORD_W(WORD_W)) u_unpack (
      .clk(clk), .rst_n(rst_n), .clear(count_load),
      .can_fetch(dir_write && active && !fifo_empty),
      .word_in(fifo_rdata), .give(tx_fire),
      .fetch(up_fetch), .have(up_have), .byte_out(up_byte)
   );

   // block boundary tracked by a down-counter instead of a modulo
   assign blk_hit = tx_fire && (blk_size != '0) &&
                    (blk_left == SIZE_W'(1) || last_byte);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q    <= '0;
         blk_left <= '0;
         xs_q     <= XS_RUN;
      end else if (count_load) begin
         rem_q    <= load_val;
         blk_left <= blk_size;
         xs_q     <= (load_val == '0) ? XS_DONE : XS_RUN;
      end else begin
         if (rx_fire || tx_fire) begin
            rem_q <= rem_q - REM_W'(1);
            if (last_byte) xs_q <= XS_DONE;
         end
         if (tx_fire)
            blk_left <= (blk_left == SIZE_W'(1)) ? blk_size : blk_left - SIZE_W'(1);
      end
   end

   assign word_moved = dir_write ? up_fetch : pk_push;

   always_comb begin
      stat_set          = '0;
      stat_set[ST_DATA] = word_moved;
      stat_set[ST_DIRQ] = word_moved && cfg_data_irq_en;
      stat_set[ST_BIRQ] = blk_hit && cfg_block_irq_en;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= (stat_q & ~stat_clr) | stat_set;
   end

   assign status = stat_q;
   assign irq    = stat_q[ST_DIRQ] | stat_q[ST_BIRQ];
   assign dbg    = {fifo_level, xs_q};
endmodule

// File: rtl/sdp_datapath_chk.sv
module sdp_datapath_chk #(
   parameter int DEPTH = 16,
   parameter int WORD_W = 32,
   parameter int REM_W = 21,
   parameter int LW = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dir_write,
   input logic              count_load,
   input logic [WORD_W-1:0] dat_rd_data,
   input logic [9:0]        stat_clr,
   input logic [9:0]        status,
   input logic [LW+3:0]     dbg,
   input logic              card_rx_valid,
   input logic              card_rx_ready,
   input logic              card_tx_valid,
   input logic [LW-1:0]     level,
   input logic [REM_W-1:0]  rem
);
   // R1: level never exceeds the depth
   a_r1_level_cap: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LW'(DEPTH));
   // R2: empty FIFO reads as zero
   a_r2_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg[LW+3:4] == '0) |-> (dat_rd_data == '0));
   // R4: no card byte accepted while full
   a_r4_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (level == LW'(DEPTH)) |-> !card_rx_ready);
   // R6: no byte offered to the card in read direction
   a_r6_tx_quiet_read: assert property (@(posedge clk) disable iff (!rst_n)
      !dir_write |-> !card_tx_valid);
   // R3: every accepted byte lowers the remaining count by one
   a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (card_rx_valid && card_rx_ready && !count_load) |=> (rem == $past(rem) - REM_W'(1)));
   // R9: state code is 0 while bytes remain
   a_r9_busy_code: assert property (@(posedge clk) disable iff (!rst_n)
      (rem != '0) |-> (dbg[3:0] == 4'h0));
   // R11: data flag is sticky until cleared
   a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (status[0] && !stat_clr[0]) |=> status[0]);
endmodule

bind sdp_datapath sdp_datapath_chk #(
   .DEPTH(DEPTH), .WORD_W(WORD_W), .REM_W(REM_W), .LW(LW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .dir_write(dir_write), .count_load(count_load),
   .dat_rd_data(dat_rd_data), .stat_clr(stat_clr), .status(status), .dbg(dbg),
   .card_rx_valid(card_rx_valid), .card_rx_ready(card_rx_ready),
   .card_tx_valid(card_tx_valid), .level(fifo_level), .rem(rem_q)
);

// File: tb/sdp_datapath_test.sv
module sdp_datapath_test;
   localparam int LW = 5;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        dir_write, cfg_data_irq_en, cfg_block_irq_en, count_load;
   logic [11:0] blk_size;
   logic [8:0]  blk_count;
   logic        dat_wr_en, dat_rd_en;
   logic [31:0] dat_wr_data, dat_rd_data;
   logic [9:0]  stat_clr, status;
   logic        irq;
   logic [8:0]  dbg;
   logic        card_rx_valid, card_rx_ready, card_tx_valid, card_tx_ready;
   logic [7:0]  card_rx_data, card_tx_data;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   sdp_datapath uut (
      .clk(clk), .rst_n(rst_n), .dir_write(dir_write),
      .cfg_data_irq_en(cfg_data_irq_en), .cfg_block_irq_en(cfg_block_irq_en),
      .blk_size(blk_size), .blk_count(blk_count), .count_load(count_load),
      .dat_wr_en(dat_wr_en), .dat_wr_data(dat_wr_data),
      .dat_rd_en(dat_rd_en), .dat_rd_data(dat_rd_data),
      .stat_clr(stat_clr), .status(status), .irq(irq), .dbg(dbg),
      .card_rx_valid(card_rx_valid), .card_rx_data(card_rx_data),
      .card_rx_ready(card_rx_ready), .card_tx_valid(card_tx_valid),
      .card_tx_data(card_tx_data), .card_tx_ready(card_tx_ready)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic sw_push(input logic [31:0] w);
      dat_wr_data = w; dat_wr_en = 1'b1;
      @(negedge clk); dat_wr_en = 1'b0;
   endtask

   task automatic sw_pop(output logic [31:0] w);
      w = dat_rd_data; dat_rd_en = 1'b1;
      @(negedge clk); dat_rd_en = 1'b0;
   endtask

   task automatic load(input int sz, input int cnt);
      blk_size = 12'(sz); blk_count = 9'(cnt); count_load = 1'b1;
      @(negedge clk); count_load = 1'b0;
   endtask

   task automatic clr(input logic [9:0] m);
      stat_clr = m;
      @(negedge clk); stat_clr = '0;
   endtask

   task automatic card_give(input logic [7:0] b);
      card_rx_data = b; card_rx_valid = 1'b1;
      while (!card_rx_ready) @(negedge clk);
      @(negedge clk); card_rx_valid = 1'b0;
   endtask

   task automatic card_take(output logic [7:0] b);
      card_tx_ready = 1'b1;
      while (!card_tx_valid) @(negedge clk);
      b = card_tx_data;
      @(negedge clk); card_tx_ready = 1'b0;
   endtask

   task automatic t_reset;
      check("R11 status after reset", 32'(status), 0);
      check("R9 dbg after reset", 32'(dbg), 0);
      check("R2 head after reset", dat_rd_data, 0);
      check("R4 rx_ready idle", 32'(card_rx_ready), 0);
      check("R6 tx_valid idle", 32'(card_tx_valid), 0);
   endtask

   task automatic t_read_pack;
      logic [31:0] w;
      dir_write = 1'b0; cfg_data_irq_en = 1'b1;
      load(6, 1);
      check("R9 state after nonzero load", 32'(dbg[3:0]), 0);
      check("R4 ready after load", 32'(card_rx_ready), 1);
      for (int i = 0; i < 6; i++) card_give(8'(8'h11 + i));
      check("R1 level after 6 bytes", 32'(dbg[LW+3:4]), 2);
      check("R9 done code", 32'(dbg[3:0]), 1);
      check("R7 data flags read", 32'(status), 32'h101);
      check("R11 irq from data flag", 32'(irq), 1);
      check("R4 ready drops at zero", 32'(card_rx_ready), 0);
      sw_pop(w); check("R4 little-endian word", w, 32'h14131211);
      sw_pop(w); check("R5 zero padded tail", w, 32'h00001615);
      clr(10'h001);
      check("R11 partial clear", 32'(status), 32'h100);
      clr(10'h100);
      check("R11 full clear", 32'(status), 0);
      check("R11 irq cleared", 32'(irq), 0);
   endtask

   task automatic t_read_full;
      logic [31:0] w;
      dir_write = 1'b0;
      load(16, 5);
      for (int i = 0; i < 64; i++) card_give(8'(i));
      check("R1 level full", 32'(dbg[LW+3:4]), 16);
      check("R4 ready low when full", 32'(card_rx_ready), 0);
      sw_pop(w); check("R4 first word", w, 32'h03020100);
      check("R4 ready after pop", 32'(card_rx_ready), 1);
      for (int i = 0; i < 4; i++) card_give(8'(8'hA0 + i));
      check("R1 refilled", 32'(dbg[LW+3:4]), 16);
      load(0, 0);
      check("R9 zero load done", 32'(dbg[3:0]), 1);
      check("R3 zero load idle", 32'(card_rx_ready), 0);
      for (int i = 0; i < 16; i++) sw_pop(w);
      check("R4 last word order", w, 32'hA3A2A1A0);
      clr(10'h3FF);
   endtask

   task automatic t_write_blocks;
      logic [7:0] b;
      dir_write = 1'b1; cfg_data_irq_en = 1'b0; cfg_block_irq_en = 1'b1;
      sw_push(32'h44332211);
      sw_push(32'h88776655);
      check("R10 push honoured in write", 32'(dbg[LW+3:4]), 2);
      load(4, 2);
      for (int i = 0; i < 4; i++) begin
         card_take(b); check("R6 byte order block 1", 32'(b), 32'(8'h11 * (i + 1)));
      end
      check("R8 block irq after block 1", 32'(status[9]), 1);
      check("R7 data flag no irq", 32'({status[8], status[0]}), 1);
      clr(10'h200);
      for (int i = 0; i < 4; i++) begin
         card_take(b); check("R6 byte order block 2", 32'(b), 32'(8'h11 * (i + 5)));
      end
      check("R8 block irq after block 2", 32'(status[9]), 1);
      check("R6 tx stops at zero", 32'(card_tx_valid), 0);
      check("R9 done after write", 32'(dbg[3:0]), 1);
      clr(10'h3FF);
   endtask

   task automatic t_write_partial;
      logic [7:0] b;
      dir_write = 1'b1; cfg_block_irq_en = 1'b0;
      sw_push(32'hDDCCBBAA);
      load(3, 1);
      card_take(b); check("R6 partial byte 0", 32'(b), 32'hAA);
      card_take(b); check("R6 partial byte 1", 32'(b), 32'hBB);
      card_take(b); check("R6 partial byte 2", 32'(b), 32'hCC);
      @(negedge clk);
      check("R6 no fourth byte", 32'(card_tx_valid), 0);
      check("R8 block irq disabled", 32'(status[9]), 0);
      check("R3 FIFO drained", 32'(dbg[LW+3:4]), 0);
      clr(10'h3FF);
   endtask

   task automatic t_overflow;
      logic [31:0] w;
      dir_write = 1'b1;
      for (int i = 0; i < 17; i++) sw_push(32'(i + 1));
      check("R1 overflow dropped", 32'(dbg[LW+3:4]), 16);
      sw_pop(w);
      check("R10 pop ignored in write", 32'(dbg[LW+3:4]), 16);
      dir_write = 1'b0;
      for (int i = 0; i < 16; i++) begin
         sw_pop(w); check("R1 FIFO order", w, 32'(i + 1));
      end
      sw_pop(w);
      check("R2 empty pop value", w, 0);
      check("R2 empty pop level", 32'(dbg[LW+3:4]), 0);
      sw_push(32'h5A5A5A5A);
      check("R10 push ignored in read", 32'(dbg[LW+3:4]), 0);
      check("R6 tx quiet in read", 32'(card_tx_valid), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      rst_n = 1'b0; dir_write = 1'b0; cfg_data_irq_en = 1'b0; cfg_block_irq_en = 1'b0;
      blk_size = '0; blk_count = '0; count_load = 1'b0;
      dat_wr_en = 1'b0; dat_wr_data = '0; dat_rd_en = 1'b0; stat_clr = '0;
      card_rx_valid = 1'b0; card_rx_data = '0; card_tx_ready = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_read_pack;
      t_read_full;
      t_write_blocks;
      t_write_partial;
      t_overflow;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule